// File: doc/BRIEF.md
# Serial Memory Power-Down and Identification Responder

This block is the command front end of a serial memory's SPI slave port (mode 0). It oversamples chip select, serial clock and serial data with the system clock and decodes the first byte of each frame. It has two jobs. It puts the device into a deep power-down state. It also answers a release instruction, which both wakes the device and returns a fixed identification byte once a 16-bit dummy address has been clocked in.

While powered down, the block discards every frame except the release instruction. A release frame starts the wake-up as soon as its eighth bit arrives, so the frame may end right after the opcode. The device then passes through a waking state that lasts a programmable number of system clocks and then returns to standby. Outside power-down, the same release instruction reads the identification byte, unless the memory core reports a busy internal operation.

Top module: `spi_pd_resp`

## Requirements
- R1: Reset leaves `pwr_state_o` at 0 (standby) and `so_oe_o` low.
- R2: SI is taken on rising SCK edges while chip select is low, most significant bit first, and the first 8 bits form the opcode.
- R3: When the opcode is OPC_RES (default 0xAB) and is accepted, the 16 bits after it are ignored. SIG_ID (default 0x29) is then driven on SO, most significant bit first, and each bit changes only after a falling SCK edge, starting with the falling edge after the 24th rising edge.
- R4: If further SCK cycles follow the first identification byte, the same byte is sent again, repeatedly, until chip select goes high.
- R5: `so_oe_o` stays low whenever chip select is high, during the 24 opcode and address bits, and throughout any frame that is not an accepted release frame.
- R6: OPC_PD (default 0xB9), received in standby while `busy_i` is low, moves `pwr_state_o` to 1 (power-down) on the chip-select rising edge, and only if exactly 8 bits were clocked. A frame of any other length leaves the state unchanged.
- R7: In power-down, every opcode other than OPC_RES is ignored: the state stays 1 and SO is never enabled.
- R8: OPC_RES in power-down moves `pwr_state_o` to 2 (waking) once its eighth bit is received. It does so even if chip select rises right after that bit. The state returns to 0 after exactly WAKE_CYC clocks in state 2.
- R9: A complete release frame sent in power-down also returns the identification byte.
- R10: In standby with `busy_i` high, OPC_RES returns no identification byte and OPC_PD has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the SPI pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock, idle low |
| si_i | input | 1 | Serial data in |
| busy_i | input | 1 | Memory core reports an erase, program or status write in progress |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for SO; the pad is high-impedance when low |
| pwr_state_o | output | 2 | 0 standby, 1 power-down, 2 waking |

## Verification
The bench sends a power-down opcode padded to nine bits. A design that compared only the opcode, and not the bit count, would wrongly power down. In power-down it sends foreign opcodes and a repeated power-down opcode, which would wrongly enable SO or wake a design that ignored the state. It cuts a release frame off straight after the opcode: a design that woke only at the end of the address would stay in power-down, and one that skipped the delay would be in standby too early. Multi-byte signature reads, and release requests while the core is busy, catch a signature that does not repeat and a busy flag that is not honoured.

// File: rtl/spi_pd_pkg.sv
package spi_pd_pkg;
  localparam int CMD_BITS  = 8;
  localparam int ADDR_BITS = 16;

  typedef enum logic [1:0] {
    PWR_STBY = 2'd0,
    PWR_DOWN = 2'd1,
    PWR_WAKE = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/spi_pd_sync.sv
module spi_pd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic si_i,
  output logic cs_o,
  output logic cs_rise_o,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic si_o
);
  logic [STAGES-1:0] cs_q, sck_q, si_q;
  logic              cs_d, sck_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cs_q  <= '1;
          sck_q <= '0;
          si_q  <= '0;
        end else begin
          cs_q  <= cs_ni;
          sck_q <= sck_i;
          si_q  <= si_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cs_q  <= '1;
          sck_q <= '0;
          si_q  <= '0;
        end else begin
          cs_q  <= {cs_q[STAGES-2:0], cs_ni};
          sck_q <= {sck_q[STAGES-2:0], sck_i};
          si_q  <= {si_q[STAGES-2:0], si_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      cs_d  <= cs_q[STAGES-1];
      sck_d <= sck_q[STAGES-1];
    end
  end

  assign cs_o       = cs_q[STAGES-1];
  assign si_o       = si_q[STAGES-1];
  assign cs_rise_o  = cs_q[STAGES-1] & ~cs_d;
  assign sck_rise_o = sck_q[STAGES-1] & ~sck_d;
  assign sck_fall_o = ~sck_q[STAGES-1] & sck_d;
endmodule

// File: rtl/spi_pd_frame.sv
module spi_pd_frame
  import spi_pd_pkg::*;
#(
  parameter logic [CMD_BITS-1:0] OPC_RES = 8'hAB,
  parameter logic [CMD_BITS-1:0] OPC_PD  = 8'hB9,
  parameter logic [CMD_BITS-1:0] SIG_ID  = 8'h29
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic cs_rise_i,
  input  logic sck_rise_i,
  input  logic sck_fall_i,
  input  logic si_i,
  input  logic pd_mode_i,
  input  logic busy_i,
  output logic res_hit_o,
  output logic pd_req_o,
  output logic so_o,
  output logic so_oe_o
);
  localparam int HDR   = CMD_BITS + ADDR_BITS;
  localparam int CNT_W = $clog2(HDR + 1);

  logic [CNT_W-1:0]    bit_cnt;
  logic [CMD_BITS-2:0] shreg;
  logic [CMD_BITS-1:0] op_w, sig_sh;
  logic                op_done, res_ok, pd_ok;
  logic                sig_frame, pd_arm, sig_act, so_q;

  assign op_w    = {shreg, si_i};
  assign op_done = sck_rise_i && !cs_i && (bit_cnt == CNT_W'(CMD_BITS - 1));
  assign res_ok  = (op_w == OPC_RES) && (pd_mode_i || !busy_i);
  assign pd_ok   = (op_w == OPC_PD) && !pd_mode_i && !busy_i;

  assign res_hit_o = op_done && (op_w == OPC_RES);
  // power-down needs exactly one byte in the frame
  assign pd_req_o  = cs_rise_i && pd_arm && (bit_cnt == CNT_W'(CMD_BITS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt   <= '0;
      shreg     <= '0;
      sig_frame <= 1'b0;
      pd_arm    <= 1'b0;
      sig_act   <= 1'b0;
      sig_sh    <= SIG_ID;
      so_q      <= 1'b0;
    end else if (cs_i) begin
      bit_cnt   <= '0;
      sig_frame <= 1'b0;
      pd_arm    <= 1'b0;
      sig_act   <= 1'b0;
      sig_sh    <= SIG_ID;
    end else begin
      if (sck_rise_i) begin
        shreg <= op_w[CMD_BITS-2:0];
        if (bit_cnt != CNT_W'(HDR)) bit_cnt <= bit_cnt + 1'b1;
        if (op_done) begin
          sig_frame <= res_ok;
          pd_arm    <= pd_ok;
        end
      end
      // rotate so the id repeats with no extra state
      if (sck_fall_i && sig_frame && (bit_cnt == CNT_W'(HDR))) begin
        so_q    <= sig_sh[CMD_BITS-1];
        sig_sh  <= {sig_sh[CMD_BITS-2:0], sig_sh[CMD_BITS-1]};
        sig_act <= 1'b1;
      end
    end
  end

  assign so_o    = so_q;
  assign so_oe_o = sig_act && !cs_i;
endmodule

// File: rtl/spi_pd_pwr.sv
module spi_pd_pwr
  import spi_pd_pkg::*;
#(
  parameter int WAKE_CYC = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pd_req_i,
  input  logic       res_hit_i,
  output logic       pd_mode_o,
  output logic [1:0] state_o
);
  localparam int CW = $clog2(WAKE_CYC + 1);

  pwr_state_e    st;
  logic [CW-1:0] wcnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st   <= PWR_STBY;
      wcnt <= '0;
    end else begin
      unique case (st)
        PWR_STBY: if (pd_req_i) st <= PWR_DOWN;
        PWR_DOWN: if (res_hit_i) begin
          st   <= PWR_WAKE;
          wcnt <= '0;
        end
        PWR_WAKE: begin
          if (wcnt == CW'(WAKE_CYC - 1)) st <= PWR_STBY;
          else wcnt <= wcnt + 1'b1;
        end
        default: st <= PWR_STBY;
      endcase
    end
  end

  assign pd_mode_o = (st != PWR_STBY);
  assign state_o   = st;
endmodule

// File: rtl/spi_pd_resp.sv
module spi_pd_resp
  import spi_pd_pkg::*;
#(
  parameter int                  SYNC_STAGES = 2,
  parameter logic [CMD_BITS-1:0] OPC_RES     = 8'hAB,
  parameter logic [CMD_BITS-1:0] OPC_PD      = 8'hB9,
  parameter logic [CMD_BITS-1:0] SIG_ID      = 8'h29,
  parameter int                  WAKE_CYC    = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       sck_i,
  input  logic       si_i,
  input  logic       busy_i,
  output logic       so_o,
  output logic       so_oe_o,
  output logic [1:0] pwr_state_o
);
  logic cs_s, cs_rise, sck_rise, sck_fall, si_s;
  logic res_hit, pd_req, pd_mode;

  spi_pd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .sck_i      (sck_i),
    .si_i       (si_i),
    .cs_o       (cs_s),
    .cs_rise_o  (cs_rise),
    .sck_rise_o (sck_rise),
    .sck_fall_o (sck_fall),
    .si_o       (si_s)
  );

  spi_pd_frame #(.OPC_RES(OPC_RES), .OPC_PD(OPC_PD), .SIG_ID(SIG_ID)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_i       (cs_s),
    .cs_rise_i  (cs_rise),
    .sck_rise_i (sck_rise),
    .sck_fall_i (sck_fall),
    .si_i       (si_s),
    .pd_mode_i  (pd_mode),
    .busy_i     (busy_i),
    .res_hit_o  (res_hit),
    .pd_req_o   (pd_req),
    .so_o       (so_o),
    .so_oe_o    (so_oe_o)
  );

  spi_pd_pwr #(.WAKE_CYC(WAKE_CYC)) u_pwr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pd_req_i  (pd_req),
    .res_hit_i (res_hit),
    .pd_mode_o (pd_mode),
    .state_o   (pwr_state_o)
  );
endmodule

// File: rtl/spi_pd_resp_chk.sv
module spi_pd_resp_chk #(
  parameter int WAKE_CYC = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_s,
  input logic       sck_fall,
  input logic       so_o,
  input logic       so_oe_o,
  input logic [1:0] pwr_state_o
);
  localparam int W = $clog2(WAKE_CYC + 2) + 1;
  logic [W-1:0] wake_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wake_len <= '0;
    else if (pwr_state_o == 2'd2) wake_len <= wake_len + 1'b1;
    else wake_len <= '0;
  end

  AST_OE_DESELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |-> !so_oe_o); // R5
  AST_SO_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (so_oe_o && $past(so_oe_o) && !$past(sck_fall)) |-> $stable(so_o)); // R3
  AST_STATE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_state_o != 2'd3); // R1
  AST_STBY_NO_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o == 2'd0) |=> (pwr_state_o != 2'd2)); // R6
  AST_DOWN_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o == 2'd1) |=> (pwr_state_o == 2'd1 || pwr_state_o == 2'd2)); // R7
  AST_WAKE_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o == 2'd2) |=> (pwr_state_o == 2'd2 || pwr_state_o == 2'd0)); // R8
  AST_WAKE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pwr_state_o) == 2'd2 && pwr_state_o == 2'd0) |-> (wake_len == W'(WAKE_CYC))); // R8
endmodule

bind spi_pd_resp spi_pd_resp_chk #(.WAKE_CYC(WAKE_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_s        (cs_s),
  .sck_fall    (sck_fall),
  .so_o        (so_o),
  .so_oe_o     (so_oe_o),
  .pwr_state_o (pwr_state_o)
);

// File: tb/tb_spi_pd_resp.sv
module tb_spi_pd_resp;
  localparam int HALF = 8;
  localparam int WAKE = 64;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1;
  logic       sck_i = 1'b0;
  logic       si_i = 1'b0;
  logic       busy_i = 1'b0;
  logic       so_o, so_oe_o;
  logic [1:0] pwr_state_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [7:0] exp_q[$];
  string      req_q[$];
  logic [7:0] acc;
  int         nbit = 0;

  always #2.5 clk = ~clk;

  spi_pd_resp #(.WAKE_CYC(WAKE)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sck_i(sck_i), .si_i(si_i),
    .busy_i(busy_i), .so_o(so_o), .so_oe_o(so_oe_o), .pwr_state_o(pwr_state_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: collect SO bits on master sampling edges, compare per byte
  always @(posedge sck_i or negedge cs_ni) begin
    if (!cs_ni && sck_i) begin
      if (so_oe_o) begin
        acc = {acc[6:0], so_o};
        nbit++;
        if (nbit == 8) begin
          nbit = 0;
          if (exp_q.size() == 0) chk("R5", "unexpected SO byte", int'(acc), -1);
          else chk(req_q.pop_front(), "id byte", int'(acc), int'(exp_q.pop_front()));
        end
      end
    end else begin
      nbit = 0;
    end
  end

  // driver: one frame, expected id bytes pushed to scoreboard
  task automatic frame(input string req, input logic [7:0] op, input int nbits, input int nsig);
    bit early_oe = 0;
    for (int k = 0; k < nsig; k++) begin
      exp_q.push_back(8'h29);
      req_q.push_back(req);
    end
    cs_ni = 1'b0;
    wclk(HALF);
    for (int i = 0; i < nbits; i++) begin
      si_i = (i < 8) ? op[7-i] : 1'b0;
      wclk(HALF);
      if (i < 24 && so_oe_o) early_oe = 1;
      sck_i = 1'b1;
      wclk(HALF);
      sck_i = 1'b0;
    end
    wclk(HALF);
    cs_ni = 1'b1;
    wclk(6);
    chk("R5", "SO enabled during opcode/address", int'(early_oe), 0);
    chk("R5", "SO enable after deselect", int'(so_oe_o), 0);
    chk(req, "scoreboard drained", exp_q.size(), 0);
    exp_q.delete();
    req_q.delete();
  endtask

  initial begin
    wclk(5);
    chk("R1", "reset state", int'(pwr_state_o), 0);
    chk("R1", "reset oe", int'(so_oe_o), 0);
    rst_ni = 1'b1;
    wclk(5);

    frame("R2 R3", 8'hAB, 32, 1);
    chk("R3", "state after standby id read", int'(pwr_state_o), 0);
    frame("R4", 8'hAB, 48, 3);
    frame("R5", 8'h03, 32, 0);
    chk("R5", "state after foreign opcode", int'(pwr_state_o), 0);

    frame("R6", 8'hB9, 9, 0);
    chk("R6", "nine-bit pd frame ignored", int'(pwr_state_o), 0);
    frame("R6", 8'hB9, 8, 0);
    chk("R6", "enter power-down", int'(pwr_state_o), 1);

    frame("R7", 8'h9F, 32, 0);
    chk("R7", "foreign opcode in pd", int'(pwr_state_o), 1);
    frame("R7", 8'hB9, 8, 0);
    chk("R7", "repeat pd opcode in pd", int'(pwr_state_o), 1);

    frame("R8", 8'hAB, 8, 0);
    chk("R8", "waking after short release", int'(pwr_state_o), 2);
    wclk(60);
    chk("R8", "standby after delay", int'(pwr_state_o), 0);

    frame("R6", 8'hB9, 8, 0);
    chk("R6", "re-enter power-down", int'(pwr_state_o), 1);
    frame("R9", 8'hAB, 32, 1);
    chk("R9", "standby after full release", int'(pwr_state_o), 0);

    busy_i = 1'b1;
    frame("R10", 8'hAB, 32, 0);
    frame("R10", 8'hB9, 8, 0);
    chk("R10", "pd ignored while busy", int'(pwr_state_o), 0);
    busy_i = 1'b0;

    frame("R3", 8'hAB, 24, 0);
    frame("R3", 8'hAB, 40, 2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule